// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the device side of a NOR-style parallel flash that takes its commands as a series of bus writes. A host writes a two-step unlock pattern to two fixed addresses and then a command code. A cycle counter and a latched command follow the host through program, erase, device-identification, fast-program and erase-pause sequences. A read returns one of three things: the stored word, an identification byte, or a status byte whose bits flip on each read while an operation is running.

A small on-chip word array stands in for the flash cells, and a down-counting timer stands in for the program and erase times. The bus is synchronous, with address, write data, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe, then holds until the next read. A `busy` output is high while a program or an erase runs. The array is split into `2**SECT_BITS` equal sectors, selected by the top address bits.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset every word reads 0xFF, `busy` is low, the sequencer is in array-read mode and `rdata` is 0x00.
- R2: A sequence opens only with 0xAA written at address UA0 and then 0x55 written at address UA1. Any other first or second write returns the sequencer to its first cycle in array-read mode.
- R3: The command 0xA0 after the unlock pair makes the next write program the word at its address to (old AND data). `busy` is then high for exactly PROG_CYC cycles.
- R4: A write of 0xF0 at any step returns the sequencer to its first cycle and to array-read mode, except when it is the data write of a program.
- R5: The command 0x90 after the unlock pair enters identification mode. Reads at address 0 return MFR_ID, at address 1 DEV_ID, and at any other address 0x00.
- R6: While `busy` is high, a read returns a status byte in which only bits 6 and 2 may be set. Bit 6 flips on every such read. Bit 2 flips only during an erase.
- R7: The command 0x80, a second unlock pair, then 0x30 at an address erases that address's sector to 0xFF after ERASE_CYC cycles. Ending with 0x10 at UA0 erases the whole array. Ending with 0x10 at any other address starts nothing.
- R8: Writes are ignored while a program or a chip erase runs. During a sector erase, only 0xB0 has an effect.
- R9: 0xB0 during a sector erase pauses it and drops `busy`. 0x30 as a first-cycle write while paused resumes it with a full ERASE_CYC count. Any other first-cycle write except 0xAA at UA0 resets the sequencer and leaves the erase paused.
- R10: While an erase is paused, reads in its sector return status with bit 2 flipping and bit 6 steady, and programs to that sector are ignored. Other sectors read and program normally.
- R11: The command 0x20 after the unlock pair enters fast-program mode. There, 0xA0 followed by a data write programs with no unlock pair, and 0x90 followed by 0x00 leaves the mode.
- R12: Reads made between the 0x80 command and the final erase write return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 8 | Write data or command code |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rd_en | input | 1 | Read strobe, one read per high cycle |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | High while a program or erase runs |

## Verification
The bench goes after the toggle bits, which must flip per read and differ by operation. A design that toggled bit 2 during a program, or bit 6 on a paused sector, fails the XOR checks. It checks that a chip erase ending at the wrong address starts nothing; a design that ignored the address would wipe the array. Resume must reload the full erase count, so a design that kept the old count would end the busy window early. Writes during a sector erase, other than pause, must be dropped; a design that accepted them would run a program and change a word in another sector. Random programs against an AND model catch a design that overwrites cells instead of clearing bits.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_CHIP, OP_SECT} op_e;
  typedef enum logic [1:0] {LC_NONE, LC_PROG, LC_ERASE, LC_BYPX} lcmd_e;

  localparam logic [7:0] C_UNLK1 = 8'hAA;
  localparam logic [7:0] C_UNLK2 = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_AUTO  = 8'h90;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_RST   = 8'hF0;
  localparam logic [7:0] C_BYPX  = 8'h00;

  // a program can only clear bits
  function automatic logic [7:0] merge_prog(logic [7:0] old_w, logic [7:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic [7:0] status_byte(logic dq6, logic dq2);
    return {1'b0, dq6, 3'b000, dq2, 2'b00};
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic [CNT_W-1:0] len,
  output logic             done,
  output logic             running
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (start)          cnt_q <= len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done    = (cnt_q == CNT_W'(1));
  assign running = (cnt_q != '0);
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SECT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [7:0]           rd_word,
  input  logic                 prog_en,
  input  logic [ADDR_W-1:0]    prog_addr,
  input  logic [7:0]           prog_data,
  input  logic                 erase_all,
  input  logic                 erase_sect,
  input  logic [SECT_BITS-1:0] erase_sel
);
  localparam int WORDS = 1 << ADDR_W;

  logic [7:0]       cells [WORDS];
  logic [WORDS-1:0] wipe;

  for (genvar g = 0; g < WORDS; g++) begin : g_wipe
    localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
    assign wipe[g] = erase_all | (erase_sect & (GA[ADDR_W-1 -: SECT_BITS] == erase_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (wipe[i])
          cells[i] <= 8'hFF;
        else if (prog_en && prog_addr == ADDR_W'(i))
          cells[i] <= merge_prog(cells[i], prog_data);
      end
    end
  end

  assign rd_word = cells[rd_addr];
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int              ADDR_W    = 6,
  parameter int              SECT_BITS = 2,
  parameter logic [ADDR_W-1:0] UA0     = 'h15,
  parameter logic [ADDR_W-1:0] UA1     = 'h2A,
  parameter int              CNT_W     = 6,
  parameter int              PROG_LEN  = 8,
  parameter int              ERASE_LEN = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  input  logic                 tmr_done,
  output op_e                  op,
  output logic                 susp,
  output logic [SECT_BITS-1:0] susp_sect,
  output logic                 autosel,
  output logic [2:0]           cyc,
  output logic                 prog_en,
  output logic                 erase_all,
  output logic                 erase_sect,
  output logic [SECT_BITS-1:0] erase_sel,
  output logic                 tmr_start,
  output logic                 tmr_clear,
  output logic [CNT_W-1:0]     tmr_len,
  output logic                 ev_prog_start,
  output logic                 ev_erase_start,
  output logic                 ev_suspend,
  output logic                 ev_resume
);
  op_e                  op_q, op_n;
  lcmd_e                lc_q, lc_n;
  logic [2:0]           cyc_q, cyc_n;
  logic                 auto_q, auto_n, byp_q, byp_n, susp_q, susp_n;
  logic [SECT_BITS-1:0] esec_q, esec_n;
  logic [SECT_BITS-1:0] wsec;
  logic                 at_ua0, at_ua1, is_rst;

  assign wsec   = addr[ADDR_W-1 -: SECT_BITS];
  assign at_ua0 = (addr == UA0);
  assign at_ua1 = (addr == UA1);
  assign is_rst = (wdata == C_RST) && !(cyc_q == 3'd3 && lc_q == LC_PROG);

  always_comb begin
    op_n = op_q;  lc_n = lc_q;  cyc_n = cyc_q;  auto_n = auto_q;
    byp_n = byp_q;  susp_n = susp_q;  esec_n = esec_q;
    prog_en = 1'b0;  erase_all = 1'b0;  erase_sect = 1'b0;
    tmr_start = 1'b0;  tmr_clear = 1'b0;  tmr_len = CNT_W'(ERASE_LEN);
    ev_prog_start = 1'b0;  ev_erase_start = 1'b0;  ev_suspend = 1'b0;  ev_resume = 1'b0;

    if (tmr_done) begin
      op_n = OP_IDLE;
      if (op_q == OP_CHIP) erase_all  = 1'b1;
      if (op_q == OP_SECT) erase_sect = 1'b1;
    end

    if (wr_en) begin
      if (op_q == OP_PROG || op_q == OP_CHIP) begin
        // busy: write dropped
      end else if (op_q == OP_SECT) begin
        if (wdata == C_SUSP && !tmr_done) begin
          op_n = OP_IDLE;  susp_n = 1'b1;  tmr_clear = 1'b1;  ev_suspend = 1'b1;
        end
      end else if (is_rst) begin
        cyc_n = 3'd0;  lc_n = LC_NONE;  auto_n = 1'b0;
      end else begin
        auto_n = 1'b0;
        cyc_n  = 3'd0;
        lc_n   = LC_NONE;
        unique case (cyc_q)
          3'd0: begin
            if (susp_q && wdata == C_SECT) begin
              op_n = OP_SECT;  susp_n = 1'b0;  tmr_start = 1'b1;  ev_resume = 1'b1;
            end else if (byp_q && wdata == C_PROG) begin
              cyc_n = 3'd3;  lc_n = LC_PROG;
            end else if (byp_q && wdata == C_AUTO) begin
              cyc_n = 3'd3;  lc_n = LC_BYPX;
            end else if (wdata == C_UNLK1 && at_ua0) begin
              cyc_n = 3'd1;
            end
          end
          3'd1: if (wdata == C_UNLK2 && at_ua1) cyc_n = 3'd2;
          3'd2: begin
            if (wdata == C_PROG) begin
              cyc_n = 3'd3;  lc_n = LC_PROG;
            end else if (!susp_q && wdata == C_ERASE) begin
              cyc_n = 3'd3;  lc_n = LC_ERASE;
            end else if (!susp_q && wdata == C_AUTO) begin
              auto_n = 1'b1;
            end else if (!susp_q && wdata == C_BYP) begin
              byp_n = 1'b1;
            end
          end
          3'd3: begin
            unique case (lc_q)
              LC_PROG: begin
                if (!(susp_q && wsec == esec_q)) begin
                  prog_en = 1'b1;  op_n = OP_PROG;  tmr_start = 1'b1;
                  tmr_len = CNT_W'(PROG_LEN);  ev_prog_start = 1'b1;
                end
              end
              LC_BYPX:  if (wdata == C_BYPX) byp_n = 1'b0;
              LC_ERASE: if (wdata == C_UNLK1 && at_ua0) begin
                cyc_n = 3'd4;  lc_n = LC_ERASE;
              end
              default: ;
            endcase
          end
          3'd4: if (wdata == C_UNLK2 && at_ua1) begin
            cyc_n = 3'd5;  lc_n = LC_ERASE;
          end
          3'd5: begin
            if (wdata == C_CHIP && at_ua0) begin
              op_n = OP_CHIP;  tmr_start = 1'b1;  ev_erase_start = 1'b1;
            end else if (wdata == C_SECT) begin
              op_n = OP_SECT;  esec_n = wsec;  tmr_start = 1'b1;  ev_erase_start = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_IDLE;  lc_q <= LC_NONE;  cyc_q <= 3'd0;  auto_q <= 1'b0;
      byp_q <= 1'b0;  susp_q <= 1'b0;  esec_q <= '0;
    end else begin
      op_q <= op_n;  lc_q <= lc_n;  cyc_q <= cyc_n;  auto_q <= auto_n;
      byp_q <= byp_n;  susp_q <= susp_n;  esec_q <= esec_n;
    end
  end

  assign op        = op_q;
  assign susp      = susp_q;
  assign susp_sect = esec_q;
  assign autosel   = auto_q;
  assign cyc       = cyc_q;
  assign erase_sel = esec_q;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int                ADDR_W    = 6,
  parameter int                SECT_BITS = 2,
  parameter logic [ADDR_W-1:0] UA0       = 'h15,
  parameter logic [ADDR_W-1:0] UA1       = 'h2A,
  parameter int                PROG_CYC  = 8,
  parameter int                ERASE_CYC = 40,
  parameter logic [7:0]        MFR_ID    = 8'h01,
  parameter logic [7:0]        DEV_ID    = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int CNT_W = $clog2(max2(PROG_CYC, ERASE_CYC) + 1);

  op_e                  op;
  logic                 susp, autosel, prog_en, erase_all, erase_sect;
  logic [SECT_BITS-1:0] susp_sect, erase_sel;
  logic [2:0]           cyc;
  logic                 tmr_start, tmr_clear, tmr_done, tmr_run;
  logic [CNT_W-1:0]     tmr_len;
  logic                 ev_prog_start, ev_erase_start, ev_suspend, ev_resume;
  logic [7:0]           arr_word;
  logic                 dq6_q, dq2_q, in_susp_sect, erasing;

  nor_cmd_fsm #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .UA0(UA0), .UA1(UA1),
    .CNT_W(CNT_W), .PROG_LEN(PROG_CYC), .ERASE_LEN(ERASE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tmr_done(tmr_done), .op(op), .susp(susp), .susp_sect(susp_sect),
    .autosel(autosel), .cyc(cyc), .prog_en(prog_en), .erase_all(erase_all),
    .erase_sect(erase_sect), .erase_sel(erase_sel), .tmr_start(tmr_start),
    .tmr_clear(tmr_clear), .tmr_len(tmr_len), .ev_prog_start(ev_prog_start),
    .ev_erase_start(ev_erase_start), .ev_suspend(ev_suspend), .ev_resume(ev_resume)
  );

  nor_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .clear(tmr_clear),
    .len(tmr_len), .done(tmr_done), .running(tmr_run)
  );

  nor_cell_array #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_word(arr_word),
    .prog_en(prog_en), .prog_addr(addr), .prog_data(wdata),
    .erase_all(erase_all), .erase_sect(erase_sect), .erase_sel(erase_sel)
  );

  assign busy         = (op != OP_IDLE);
  assign erasing      = (op == OP_CHIP) || (op == OP_SECT);
  assign in_susp_sect = susp && (addr[ADDR_W-1 -: SECT_BITS] == susp_sect);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 8'h00;  dq6_q <= 1'b0;  dq2_q <= 1'b0;
    end else if (rd_en) begin
      if (busy) begin
        dq6_q <= ~dq6_q;
        if (erasing) dq2_q <= ~dq2_q;
        rdata <= status_byte(~dq6_q, erasing ? ~dq2_q : dq2_q);
      end else if (in_susp_sect) begin
        dq2_q <= ~dq2_q;
        rdata <= status_byte(dq6_q, ~dq2_q);
      end else if (autosel) begin
        rdata <= (addr == '0) ? MFR_ID : (addr == ADDR_W'(1)) ? DEV_ID : 8'h00;
      end else begin
        rdata <= arr_word;
      end
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rd_en,
  input logic [2:0] cyc,
  input logic       susp,
  input logic       dq6_st,
  input logic       tmr_done,
  input logic       ev_prog_start,
  input logic       ev_erase_start,
  input logic       ev_suspend,
  input logic       ev_resume
);
  // R2
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cyc <= 3'd5);

  // R8
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_prog_start || ev_erase_start) |-> !busy);

  // R9
  suspend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_suspend |=> (!busy && susp));

  // R9
  resume_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resume |=> (busy && !susp));

  // R6
  dq6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (dq6_st != $past(dq6_st)));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(tmr_done) || $past(ev_suspend)));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en), .cyc(cyc), .susp(susp),
  .dq6_st(dq6_q), .tmr_done(tmr_done), .ev_prog_start(ev_prog_start),
  .ev_erase_start(ev_erase_start), .ev_suspend(ev_suspend), .ev_resume(ev_resume)
);

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module nor_cmd_seq_bench;
  localparam logic [5:0] UA0 = 6'h15;
  localparam logic [5:0] UA1 = 6'h2A;
  localparam int PROG_CYC = 8;
  localparam int ERASE_CYC = 40;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, busy;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] mdl [64];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nor_cmd_seq u_nor_cmd_seq (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .busy(busy));

  function automatic logic [7:0] exp_prog(logic [7:0] o, logic [7:0] n);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = o[b] ? n[b] : 1'b0;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic unlock();
    wr(UA0, 8'hAA); wr(UA1, 8'h55);
  endtask

  task automatic prog(input logic [5:0] a, input logic [7:0] d);
    int n;
    unlock(); wr(UA0, 8'hA0); wr(a, d); wait_idle(n);
    mdl[a] = exp_prog(mdl[a], d);
  endtask

  task automatic erase_seq(input logic [5:0] a, input logic [7:0] c);
    unlock(); wr(UA0, 8'h80); unlock(); wr(a, c);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] r, s1, s2;
    int n;
    void'($urandom(32'h1234));
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rdata == 8'h00, "R1", rdata, 0);
    check(busy == 1'b0, "R1", busy, 0);
    rd(6'h05, r); check(r == 8'hFF, "R1", r, 8'hFF);

    // R3 program and busy length
    unlock(); wr(UA0, 8'hA0); wr(6'h05, 8'h3C);
    wait_idle(n); mdl[5] = exp_prog(mdl[5], 8'h3C);
    check(n == PROG_CYC, "R3", n, PROG_CYC);
    rd(6'h05, r); check(r == mdl[5], "R3", r, mdl[5]);
    prog(6'h05, 8'h66);
    rd(6'h05, r); check(r == mdl[5], "R3", r, mdl[5]);

    // R6 program status: only bit 6 toggles
    unlock(); wr(UA0, 8'hA0); wr(6'h06, 8'h0F);
    rd(6'h06, s1); rd(6'h06, s2);
    check((s1 ^ s2) == 8'h40, "R6", s1 ^ s2, 8'h40);
    check((s2 & 8'hBB) == 0, "R6", s2, 0);
    wait_idle(n); mdl[6] = exp_prog(mdl[6], 8'h0F);

    // R2 broken unlock
    wr(UA0, 8'h12); wr(UA1, 8'h55); wr(UA0, 8'hA0); wr(6'h05, 8'h00);
    check(busy == 1'b0, "R2", busy, 0);
    wr(UA1, 8'hAA); wr(UA1, 8'h55); wr(UA0, 8'hA0); wr(6'h05, 8'h00);
    rd(6'h05, r); check(r == mdl[5], "R2", r, mdl[5]);

    // R4 reset mid-sequence
    unlock(); wr(UA0, 8'hF0); wr(UA0, 8'hA0); wr(6'h05, 8'h00);
    rd(6'h05, r); check(r == mdl[5], "R4", r, mdl[5]);

    // R5 identification
    unlock(); wr(UA0, 8'h90);
    rd(6'h00, r); check(r == 8'h01, "R5", r, 8'h01);
    rd(6'h01, r); check(r == 8'h7E, "R5", r, 8'h7E);
    rd(6'h02, r); check(r == 8'h00, "R5", r, 0);
    wr(6'h00, 8'hF0);
    rd(6'h00, r); check(r == mdl[0], "R4", r, mdl[0]);

    // R11 fast-program mode
    unlock(); wr(UA0, 8'h20);
    wr(6'h00, 8'hA0); wr(6'h09, 8'h5A); wait_idle(n); mdl[9] = exp_prog(mdl[9], 8'h5A);
    rd(6'h09, r); check(r == mdl[9], "R11", r, mdl[9]);
    wr(6'h00, 8'h90); wr(6'h00, 8'h00);
    wr(6'h00, 8'hA0); wr(6'h09, 8'h00);
    check(busy == 1'b0, "R11", busy, 0);
    rd(6'h09, r); check(r == mdl[9], "R11", r, mdl[9]);

    // R7 R12 R8 sector erase of sector 1
    prog(6'h12, 8'h00); prog(6'h1F, 8'h81);
    unlock(); wr(UA0, 8'h80);
    rd(6'h05, r); check(r == mdl[5], "R12", r, mdl[5]);
    wr(UA0, 8'hAA);
    rd(6'h12, r); check(r == mdl[6'h12], "R12", r, mdl[6'h12]);
    wr(UA1, 8'h55); wr(6'h13, 8'h30);
    rd(6'h00, s1); rd(6'h00, s2);
    check((s1 ^ s2) == 8'h44, "R6", s1 ^ s2, 8'h44);
    unlock(); wr(UA0, 8'hA0); wr(6'h05, 8'h00);
    wait_idle(n);
    mdl[6'h12] = 8'hFF; mdl[6'h1F] = 8'hFF;
    rd(6'h12, r); check(r == 8'hFF, "R7", r, 8'hFF);
    rd(6'h1F, r); check(r == 8'hFF, "R7", r, 8'hFF);
    rd(6'h05, r); check(r == mdl[5], "R8", r, mdl[5]);

    // R7 chip erase address rule, R8 writes dropped
    erase_seq(UA1, 8'h10);
    check(busy == 1'b0, "R7", busy, 0);
    erase_seq(UA0, 8'h10);
    check(busy == 1'b1, "R7", busy, 1);
    wr(6'h00, 8'hB0);
    check(busy == 1'b1, "R8", busy, 1);
    wait_idle(n);
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    rd(6'h05, r); check(r == 8'hFF, "R7", r, 8'hFF);
    rd(6'h09, r); check(r == 8'hFF, "R7", r, 8'hFF);

    // R9 R10 suspend / resume on sector 2
    prog(6'h25, 8'h11); prog(6'h03, 8'h22);
    erase_seq(6'h20, 8'h30);
    wr(6'h00, 8'hB0);
    check(busy == 1'b0, "R9", busy, 0);
    rd(6'h25, s1); rd(6'h25, s2);
    check((s1 ^ s2) == 8'h04, "R10", s1 ^ s2, 8'h04);
    rd(6'h03, r); check(r == mdl[3], "R10", r, mdl[3]);
    prog(6'h03, 8'h02);
    rd(6'h03, r); check(r == mdl[3], "R10", r, mdl[3]);
    unlock(); wr(UA0, 8'hA0); wr(6'h26, 8'h00);
    check(busy == 1'b0, "R10", busy, 0);
    wr(6'h00, 8'h77);
    rd(6'h25, r); check((r & 8'hBB) == 0, "R9", r, 0);
    wr(6'h00, 8'h30);
    check(busy == 1'b1, "R9", busy, 1);
    wait_idle(n);
    check(n == ERASE_CYC, "R9", n, ERASE_CYC);
    mdl[6'h25] = 8'hFF;
    rd(6'h25, r); check(r == 8'hFF, "R9", r, 8'hFF);
    rd(6'h26, r); check(r == 8'hFF, "R10", r, 8'hFF);
    rd(6'h03, r); check(r == mdl[3], "R9", r, mdl[3]);

    // R3 random programs against the AND model
    for (int k = 0; k < 24; k++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = 6'($urandom() % 64);
      d = 8'($urandom());
      if (d == 8'hF0) d = 8'hE0;
      prog(a, d);
    end
    for (int i = 0; i < 64; i++) begin
      rd(6'(i), r);
      if (r != mdl[i]) check(1'b0, "R3", r, mdl[i]);
    end
    check(1'b1, "R3", 0, 0);

    finish_run();
  end
endmodule